// File: doc/BRIEF.md
# Receive Link Fault Aggregator

This block turns the health flags of four receive channels into one active-low link fault indicator per channel. Each channel reports whether its incoming amplitude clears each of three detection thresholds, whether its transition density is acceptable, and whether its recovered clock frequency is inside the normal range. A single two-bit select picks which amplitude threshold counts for every channel. A channel shows a good link only when all of its terms hold and the channel is enabled. When a channel runs in local loopback, the amplitude term is dropped, and the channel's serial transmit output is held at a constant one.

Channel enables come from a shared eight-bit bus through a level-sensitive hold stage. While the strobe is high the bus drives the enables directly. While the strobe is low they keep their last values. After a channel is enabled, a counter holds its fault indicator asserted for a set number of cycles, which covers the time its status is not yet valid. The window length is a parameter. For real silicon it is about 2 ms. A bench can set it short.

Top module: `link_fault_agg`

## Requirements
- R1: `link_ok_n[c]` is high only when `freq_ok[c]`, `dens_ok[c]`, the channel enable and the amplitude term all hold and no settle window is running. If any one of them fails, the output is low in the same cycle.
- R2: The amplitude term of channel c is `amp_ok[3c + k]`, where k is chosen by `thr_sel`: 00 selects k=0 (lowest threshold), 01 selects k=1 (middle), 10 selects k=2 (highest), and 11 selects k=1 (middle).
- R3: While `loop_en[c]` is high, the amplitude term of channel c is ignored. The output then depends only on frequency, density, enable and settle state.
- R4: `tx_force_one[c]` equals `loop_en[c]` at all times.
- R5: While `en_strobe` is high, `chan_en[c]` equals `en_bus[2c]` combinationally. The odd bits `en_bus[2c+1]` have no effect on any output.
- R6: While `en_strobe` is low, `chan_en` keeps the value it had when the strobe fell, whatever `en_bus` does.
- R7: A disabled channel always drives `link_ok_n[c]` low.
- R8: When `chan_en[c]` rises, `link_ok_n[c]` stays low from that cycle through the next SETTLE_CYCLES clock edges, and is then released. Disabling the channel cancels the window.
- R9: While `rst_n` is low and the strobe is low, all enables read 0 and all fault indicators are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_sel | input | 2 | Shared amplitude threshold select |
| amp_ok | input | 3*NUM_CH | Per-channel amplitude-above-threshold flags, 3 per channel |
| dens_ok | input | NUM_CH | Transition density acceptable |
| freq_ok | input | NUM_CH | Recovered frequency within range |
| loop_en | input | NUM_CH | Local loopback enable |
| en_bus | input | 2*NUM_CH | Shared enable bus, bit 2c drives channel c |
| en_strobe | input | 1 | Enable pass/hold strobe |
| link_ok_n | output | NUM_CH | Active-low link fault indicator (low = fault) |
| chan_en | output | NUM_CH | Current channel enables |
| tx_force_one | output | NUM_CH | Force serial transmit to constant one |

## Verification
Most of the block is combinational from its inputs, so a wrong decode of the threshold or a wrong loopback term appears on `link_ok_n` in the same cycle as the input pattern that exposes it. The bench sweeps every combination of the select and the per-channel flags. The only internal state is the held enable and the settle counter. A bad hold register shows on `chan_en` the first cycle after the strobe falls. A wrong counter load or decrement moves the release of `link_ok_n` by one or more edges relative to the enabling cycle, and the bench checks that edge by edge.

// File: rtl/lfa_pkg.sv
// Shared types and helpers for the link fault aggregator.
// Assumes a 2-bit threshold code. Code 11 is treated as the middle level.
package lfa_pkg;

    typedef enum logic [1:0] {
        THR_LOW  = 2'b00,
        THR_MID  = 2'b01,
        THR_HIGH = 2'b10,
        THR_ALT  = 2'b11
    } thr_sel_e;

    // Select the amplitude flag that the current threshold code names.
    function automatic logic pick_amp(input logic [2:0] ok, input logic [1:0] sel);
        logic r;
        case (thr_sel_e'(sel))
            THR_LOW:  r = ok[0];
            THR_HIGH: r = ok[2];
            default:  r = ok[1];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lfa_en_hold.sv
// Enable pass/hold stage for one channel.
// While the strobe is high the bus bit passes straight through. While it is
// low, the value captured at the last clock edge with the strobe high is held.
// Assumes the strobe is high for at least one clock edge with the bus stable.
module lfa_en_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic en_bit,
    output logic en_o
);
    logic held_q;

    // Capture the bus bit on every edge while the strobe is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (strobe)
            held_q <= en_bit;
    end

    // Pass through when open, otherwise present the held value.
    always_comb begin
        en_o = strobe ? en_bit : held_q;
    end
endmodule

// File: rtl/lfa_settle_timer.sv
// Post-enable settle window for one channel.
// When the enable rises, busy is high in that cycle and for the next
// SETTLE_CYCLES clock edges. A low enable clears the window.
// Assumes SETTLE_CYCLES >= 1.
module lfa_settle_timer #(
    parameter int SETTLE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic             en_d;
    logic [CNT_W-1:0] cnt_q;

    // Track the previous enable and run the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            cnt_q <= '0;
        end else begin
            en_d <= en;
            if (!en)
                cnt_q <= '0;
            else if (!en_d)
                cnt_q <= CNT_W'(SETTLE_CYCLES);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Busy in the rising cycle and while the count is non-zero.
    always_comb begin
        busy = en && (!en_d || (cnt_q != '0));
    end
endmodule

// File: rtl/lfa_health_eval.sv
// Combines one channel's health terms into an active-low fault indicator.
// In loopback the amplitude term is dropped and the transmit output is forced
// to one. Purely combinational.
module lfa_health_eval
    import lfa_pkg::*;
(
    input  logic [2:0] amp_ok,
    input  logic [1:0] thr_sel,
    input  logic       dens_ok,
    input  logic       freq_ok,
    input  logic       loop_en,
    input  logic       en,
    input  logic       settling,
    output logic       ok_n,
    output logic       tx_one
);
    logic amp_term;

    // Amplitude term: selected threshold, bypassed in loopback.
    always_comb begin
        amp_term = loop_en || pick_amp(amp_ok, thr_sel);
    end

    // Indicator is high only when every term holds.
    always_comb begin
        ok_n   = en && !settling && dens_ok && freq_ok && amp_term;
        tx_one = loop_en;
    end
endmodule

// File: rtl/link_fault_agg.sv
// Top of the link fault aggregator: one hold stage, settle timer and health
// evaluator per receive channel. Channel c takes its enable from en_bus[2c].
// The odd bus bits are not used.
module link_fault_agg #(
    parameter int NUM_CH        = 4,
    parameter int SETTLE_CYCLES = 100000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            thr_sel,
    input  logic [3*NUM_CH-1:0]   amp_ok,
    input  logic [NUM_CH-1:0]     dens_ok,
    input  logic [NUM_CH-1:0]     freq_ok,
    input  logic [NUM_CH-1:0]     loop_en,
    input  logic [2*NUM_CH-1:0]   en_bus,
    input  logic                  en_strobe,
    output logic [NUM_CH-1:0]     link_ok_n,
    output logic [NUM_CH-1:0]     chan_en,
    output logic [NUM_CH-1:0]     tx_force_one
);
    localparam int BUS_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] settling;
    logic [NUM_CH-1:0] unused_odd_bits;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign unused_odd_bits[c] = en_bus[(2*c+1) % BUS_W];

        lfa_en_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (en_strobe),
            .en_bit (en_bus[2*c]),
            .en_o   (chan_en[c])
        );

        lfa_settle_timer #(
            .SETTLE_CYCLES (SETTLE_CYCLES)
        ) u_settle (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (chan_en[c]),
            .busy  (settling[c])
        );

        lfa_health_eval u_eval (
            .amp_ok   (amp_ok[3*c +: 3]),
            .thr_sel  (thr_sel),
            .dens_ok  (dens_ok[c]),
            .freq_ok  (freq_ok[c]),
            .loop_en  (loop_en[c]),
            .en       (chan_en[c]),
            .settling (settling[c]),
            .ok_n     (link_ok_n[c]),
            .tx_one   (tx_force_one[c])
        );
    end
endmodule

// File: rtl/link_fault_agg_chk.sv
// Port-level checker for the link fault aggregator, bound to the top module.
module link_fault_agg_chk
    import lfa_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          thr_sel,
    input logic [3*NUM_CH-1:0] amp_ok,
    input logic [NUM_CH-1:0]   dens_ok,
    input logic [NUM_CH-1:0]   freq_ok,
    input logic [NUM_CH-1:0]   loop_en,
    input logic [2*NUM_CH-1:0] en_bus,
    input logic                en_strobe,
    input logic [NUM_CH-1:0]   link_ok_n,
    input logic [NUM_CH-1:0]   chan_en,
    input logic [NUM_CH-1:0]   tx_force_one
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_disabled_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[c] |-> !link_ok_n[c]);

        assert_all_terms_R1: assert property (@(posedge clk) disable iff (!rst_n)
            link_ok_n[c] |-> (freq_ok[c] && dens_ok[c] && chan_en[c]));

        assert_amp_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (link_ok_n[c] && !loop_en[c]) |-> pick_amp(amp_ok[3*c +: 3], thr_sel));

        assert_tx_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tx_force_one[c] == loop_en[c]);

        assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
            en_strobe |-> (chan_en[c] == en_bus[2*c]));

        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_strobe && $past(!en_strobe)) |-> $stable(chan_en[c]));

        assert_settle_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_en[c]) |-> !link_ok_n[c]);
    end
endmodule

bind link_fault_agg link_fault_agg_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/link_fault_agg_bench.sv
module link_fault_agg_bench;
    localparam int NCH    = 4;
    localparam int SETTLE = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       thr_sel;
    logic [3*NCH-1:0] amp_ok;
    logic [NCH-1:0]   dens_ok, freq_ok, loop_en;
    logic [2*NCH-1:0] en_bus;
    logic             en_strobe;
    logic [NCH-1:0]   link_ok_n, chan_en, tx_force_one;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    link_fault_agg #(.NUM_CH(NCH), .SETTLE_CYCLES(SETTLE)) u_link_fault_agg (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel), .amp_ok(amp_ok),
        .dens_ok(dens_ok), .freq_ok(freq_ok), .loop_en(loop_en),
        .en_bus(en_bus), .en_strobe(en_strobe), .link_ok_n(link_ok_n),
        .chan_en(chan_en), .tx_force_one(tx_force_one)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_ok(input logic [2:0] amp, input logic [1:0] sel,
                                    input logic tr, input logic fr, input logic lb,
                                    input logic en);
        int k;
        k = (sel == 2'b00) ? 0 : (sel == 2'b10) ? 2 : 1;
        return en & tr & fr & (lb | amp[k]);
    endfunction

    function automatic logic [NCH-1:0] even_bits(input logic [2*NCH-1:0] b);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = b[2*c];
        return r;
    endfunction

    task automatic all_good();
        amp_ok = '1; dens_ok = '1; freq_ok = '1; loop_en = '0; thr_sel = 2'b01;
    endtask

    initial begin
        rst_n = 1'b0; en_strobe = 1'b0; en_bus = '0;
        all_good();
        repeat (3) @(posedge clk);
        #5;
        // R9: state during reset
        chk("R9 chan_en in reset", 32'(chan_en), 0);
        chk("R9 link_ok_n in reset", 32'(link_ok_n), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #5;
        chk("R9 chan_en after reset", 32'(chan_en), 0);
        chk("R9 link_ok_n after reset", 32'(link_ok_n), 0);

        // R5 / R7: pass-through over every bus value, odd bits ignored
        en_strobe = 1'b1;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            en_bus = 8'(v);
            #5;
            chk("R5 pass-through", 32'(chan_en), 32'(even_bits(8'(v))));
            for (int c = 0; c < NCH; c++)
                if (!en_bus[2*c]) chk("R7 disabled fault", 32'(link_ok_n[c]), 0);
        end

        // R6: hold while strobe low
        @(negedge clk) en_bus = 8'h55;
        @(negedge clk) en_strobe = 1'b0;
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            en_bus = 8'(v);
            #5;
            chk("R6 hold", 32'(chan_en), 32'hF);
        end
        @(negedge clk) en_strobe = 1'b1; en_bus = 8'h00;
        @(negedge clk) en_strobe = 1'b0;
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            en_bus = 8'(v * 17);
            #5;
            chk("R6 hold zero", 32'(chan_en), 0);
        end

        // Enable all, wait past settle window
        @(negedge clk) en_strobe = 1'b1; en_bus = 8'hFF;
        @(negedge clk) en_strobe = 1'b0;
        repeat (SETTLE + 3) @(negedge clk);

        // R1 / R2 / R3 / R4: exhaustive sweep
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            thr_sel = 2'(i);
            for (int c = 0; c < NCH; c++) begin
                int p;
                p = ((i >> 2) + 13 * c) & 63;
                amp_ok[3*c +: 3] = 3'(p);
                dens_ok[c] = p[3];
                freq_ok[c] = p[4];
                loop_en[c] = p[5];
            end
            #5;
            for (int c = 0; c < NCH; c++) begin
                logic e;
                e = exp_ok(amp_ok[3*c +: 3], thr_sel, dens_ok[c], freq_ok[c], loop_en[c], 1'b1);
                if (loop_en[c])
                    chk("R3 loopback ignores amplitude", 32'(link_ok_n[c]), 32'(e));
                else
                    chk("R1 R2 term combination", 32'(link_ok_n[c]), 32'(e));
                chk("R4 transmit force", 32'(tx_force_one[c]), 32'(loop_en[c]));
            end
        end

        // R8: settle window on channel 2
        @(negedge clk);
        all_good();
        en_strobe = 1'b1; en_bus = 8'h45;
        repeat (3) @(negedge clk);
        chk("R7 channel 2 off", 32'(link_ok_n), 32'hB);
        en_bus = 8'h55;
        #5;
        chk("R8 rise cycle", 32'(link_ok_n[2]), 0);
        for (int k = 1; k <= SETTLE; k++) begin
            @(posedge clk); #5;
            chk("R8 within window", 32'(link_ok_n[2]), 0);
            chk("R8 others unaffected", 32'(link_ok_n & 4'hB), 32'hB);
        end
        @(posedge clk); #5;
        chk("R8 release", 32'(link_ok_n[2]), 1);

        // R8: disable mid-window cancels it
        @(negedge clk) en_bus = 8'h45;
        @(negedge clk) en_bus = 8'h55;
        @(negedge clk) en_bus = 8'h45;
        @(negedge clk) en_bus = 8'h55;
        for (int k = 1; k <= SETTLE; k++) begin
            @(posedge clk); #5;
            chk("R8 restart window", 32'(link_ok_n[2]), 0);
        end
        @(posedge clk); #5;
        chk("R8 restart release", 32'(link_ok_n[2]), 1);

        // R7: disable an enabled, healthy channel
        @(negedge clk) en_bus = 8'h54;
        #5;
        chk("R7 immediate disable", 32'(link_ok_n), 32'hE);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule